// File: doc/BRIEF.md
# SPI Serial Memory Command Slave

This block is the serial front end of a small byte-wide nonvolatile memory model. An SPI master selects it by pulling the active-low select low. The master then sends an 8-bit command. Depending on the command, a 16-bit address and data bytes follow, or status bytes are returned. All bits travel most significant bit first. The slave samples its input on rising SCK edges and changes its output on falling SCK edges, which serves both clock modes 0 and 3.

All serial pins are brought into the system clock domain through two-flop synchronisers. Edges are found there, so the system clock must run at least 8 times faster than SCK. Behind the front end sits a synchronous RAM of `1 << ADDR_W` bytes. Array writes and status writes start a timed internal write cycle. During that cycle only the status read command is honoured. A pause input freezes a transfer part way through without losing its bit position. Serial output is modelled as a data bit plus an output enable; the enable low stands for high impedance.

The control FSM has eight states:
- `S_IDLE`: not selected.
- `S_OPC`: shifting in the command byte.
- `S_ADDR`: shifting in the 16 address bits.
- `S_RDARR`: streaming array bytes out.
- `S_WRARR`: taking array bytes in.
- `S_RDST`: streaming status out.
- `S_WRST`: taking the status byte in.
- `S_SKIP`: ignoring the rest of the transfer.

Transitions:
- A select rise sends any state to `S_IDLE`, and a select fall sends it to `S_OPC`.
- At the end of the command byte, `S_OPC` goes to `S_ADDR`, `S_RDST`, `S_WRST` or `S_SKIP`.
- At the end of the address, `S_ADDR` goes to `S_RDARR` or `S_WRARR`.
- `S_WRST` goes to `S_SKIP` after its one byte.

Top module: `spi_mem_slave`

## Requirements
- R1: While select is high, `so_oe` is low. After reset, the status byte reads 0x00.
- R2: A command byte has the form 0000_x_b2b1b0, and bit 3 has no effect. Codes b2b1b0: 110 sets write enable, 100 clears it, 101 reads status, 001 writes status, 011 reads the array, 010 writes the array.
- R3: The set-enable command makes status bit 1 read 1, and the clear-enable command makes it read 0.
- R4: An array write or status write that arrives while write enable is 0 changes nothing and starts no write cycle.
- R5: After a select rise that ends an accepted write, status reads 0xFF for WR_CYCLES system clocks. In that window every other command is ignored, including a read, which leaves `so_oe` low. When the window ends, bit 0 and write enable read 0.
- R6: The read command is followed by a 16-bit address. Address bits above ADDR_W are ignored.
- R7: A read streams bytes from consecutive addresses and wraps from the top address to address 0.
- R8: Array write bytes go to consecutive addresses. Only the low PAGE_BITS address bits step, so a write wraps inside its 32-byte page.
- R9: A command byte with a nonzero upper nibble or an undefined b2b1b0 code makes the slave ignore the rest of the transfer with `so_oe` low. The next select works normally.
- R10: Pulling `hold_n` low while SCK is low pauses the transfer. The pause ends only when `hold_n` is raised while SCK is low. While paused, `so_oe` is low, SCK edges and `si` are ignored, and the bit position is kept.
- R11: Status byte layout is: bit 0 write in progress, bit 1 write enable, bits 3:2 protect field, other bits 0. A status write loads bits 3:2.
- R12: Transfers work both with SCK idling low (mode 0) and with SCK idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |

## Verification
The bench reads back the top address followed by address 0 in one transfer; a design that stopped or did not wrap would return the wrong second byte. It writes three bytes starting two below a page boundary; a design that carried into the upper address bits would leave page start unwritten. It pauses a read in the middle of a data byte while toggling SCK; a design that let those edges through or dropped its bit count would return a corrupted byte or drive the output while paused. It issues commands while a write cycle runs and under bit 3 variants; a design that did not gate on the busy state would show a read driving data or write enable surviving the cycle.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_OPC, S_ADDR, S_RDARR, S_WRARR, S_RDST, S_WRST, S_SKIP
    } st_t;

    localparam logic [2:0] OP_SETWE = 3'b110;
    localparam logic [2:0] OP_CLRWE = 3'b100;
    localparam logic [2:0] OP_RDST  = 3'b101;
    localparam logic [2:0] OP_WRST  = 3'b001;
    localparam logic [2:0] OP_RDARR = 3'b011;
    localparam logic [2:0] OP_WRARR = 3'b010;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta   <= RST_VAL;
            q      <= RST_VAL;
            q_prev <= RST_VAL;
        end else begin
            meta   <= d;
            q      <= meta;
            q_prev <= q;
        end
    end
endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 5,
    parameter int WR_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [3:0] s_now, s_old;
    spi_in_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({hold_n, cs_n, sck, si}),
        .q(s_now), .q_prev(s_old)
    );
    logic s_hold, s_cs, s_sck, s_si;
    assign {s_hold, s_cs, s_sck, s_si} = s_now;

    logic sck_r, sck_f, cs_fall, cs_rise;
    assign sck_r   = s_sck & ~s_old[1];
    assign sck_f   = ~s_sck & s_old[1];
    assign cs_fall = ~s_cs & s_old[2];
    assign cs_rise = s_cs & ~s_old[2];

    st_t state, nstate;
    logic held, act;
    logic [3:0] cnt;
    logic [2:0] ocnt;
    logic [7:0] shreg, obyte;
    logic [14:0] addr_sh;
    logic [ADDR_W-1:0] addr, raddr;
    logic is_rd, wel, busy, wrote, rd_pend, so_q;
    logic [1:0] prot;
    logic [CNT_W-1:0] bcnt;
    logic [7:0] ram_q;

    assign act = ~s_cs & ~held;

    logic [7:0] inbyte, status;
    logic [15:0] addr_full;
    logic [2:0] op;
    logic hi_ok, byte_done, adone, ram_we, rd_issue;
    assign inbyte    = {shreg[6:0], s_si};
    assign op        = inbyte[2:0];
    assign hi_ok     = (inbyte[7:4] == 4'h0);
    assign addr_full = {addr_sh, s_si};
    assign byte_done = sck_r && act && (cnt[2:0] == 3'd7);
    assign adone     = sck_r && act && (cnt == 4'hF);
    assign status    = busy ? 8'hFF : {4'b0, prot, wel, 1'b0};
    assign ram_we    = (state == S_WRARR) && byte_done;
    assign raddr     = (state == S_ADDR) ? addr_full[ADDR_W-1:0] : addr;
    assign rd_issue  = act && (((state == S_ADDR) && adone && is_rd) ||
                               ((state == S_RDARR) && sck_f && (ocnt == 3'd7)));

    spi_mem_ram #(.AW(ADDR_W), .DW(8)) u_ram (
        .clk(clk), .we(ram_we), .waddr(addr), .wdata(inbyte),
        .re(rd_issue), .raddr(raddr), .rdata(ram_q)
    );

    // next-state logic
    always_comb begin
        nstate = state;
        if (s_cs) nstate = S_IDLE;
        else if (cs_fall) nstate = S_OPC;
        else begin
            unique case (state)
                S_OPC: if (byte_done) begin
                    if (!hi_ok || (busy && op != OP_RDST)) nstate = S_SKIP;
                    else begin
                        unique case (op)
                            OP_RDST:  nstate = S_RDST;
                            OP_WRST:  nstate = wel ? S_WRST : S_SKIP;
                            OP_RDARR: nstate = S_ADDR;
                            OP_WRARR: nstate = wel ? S_ADDR : S_SKIP;
                            default:  nstate = S_SKIP;
                        endcase
                    end
                end
                S_ADDR:  if (adone) nstate = is_rd ? S_RDARR : S_WRARR;
                S_WRST:  if (byte_done) nstate = S_SKIP;
                S_IDLE, S_RDARR, S_WRARR, S_RDST, S_SKIP: nstate = state;
                default: nstate = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= 1'b0; cnt <= '0; ocnt <= '0; shreg <= '0; obyte <= '0;
            addr_sh <= '0; addr <= '0; is_rd <= 1'b0; wel <= 1'b0;
            busy <= 1'b0; wrote <= 1'b0; rd_pend <= 1'b0; so_q <= 1'b0;
            prot <= '0; bcnt <= '0;
        end else begin
            if (s_cs)        held <= 1'b0;
            else if (!s_sck) held <= ~s_hold;
            rd_pend <= rd_issue;
            if (rd_pend) obyte <= ram_q;
            if (busy) begin
                if (bcnt == CNT_W'(1)) begin busy <= 1'b0; wel <= 1'b0; end
                bcnt <= bcnt - 1'b1;
            end
            if (cs_fall) begin cnt <= '0; ocnt <= '0; end
            if (cs_rise) begin
                wrote <= 1'b0;
                if (wrote) begin busy <= 1'b1; bcnt <= CNT_W'(WR_CYCLES); end
            end
            if (sck_r && act && state != S_IDLE && state != S_SKIP) begin
                shreg <= inbyte;
                cnt   <= cnt + 1'b1;
            end
            unique case (state)
                S_OPC: if (byte_done) begin
                    cnt   <= '0;
                    is_rd <= (op == OP_RDARR);
                    if (hi_ok && !busy && op == OP_SETWE) wel <= 1'b1;
                    if (hi_ok && !busy && op == OP_CLRWE) wel <= 1'b0;
                    if (op == OP_RDST) obyte <= status;
                end
                S_ADDR: begin
                    if (sck_r && act) addr_sh <= addr_full[14:0];
                    if (adone) begin
                        cnt <= '0;
                        if (!is_rd) addr <= addr_full[ADDR_W-1:0];
                    end
                end
                S_WRARR: if (byte_done) begin
                    cnt   <= '0;
                    addr  <= {addr[ADDR_W-1:PAGE_BITS], addr[PAGE_BITS-1:0] + 1'b1};
                    wrote <= 1'b1;
                end
                S_WRST: if (byte_done) begin
                    prot  <= inbyte[3:2];
                    wrote <= 1'b1;
                end
                S_RDST: if (sck_f && act) begin
                    so_q <= obyte[3'd7 - ocnt];
                    ocnt <= ocnt + 1'b1;
                    if (ocnt == 3'd7) obyte <= status;
                end
                S_RDARR: if (sck_f && act) begin
                    so_q <= obyte[3'd7 - ocnt];
                    ocnt <= ocnt + 1'b1;
                end
                S_IDLE, S_SKIP: ;
                default: ;
            endcase
            if (rd_issue) addr <= raddr + 1'b1;
        end
    end

    // outputs
    always_comb begin
        so_oe = act && (state == S_RDARR || state == S_RDST);
        so    = so_q;
    end

    a_r4_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> wel);
    a_r5_no_access_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!ram_we && !rd_issue));
    a_r5_wel_drops_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);
    a_r10_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> !so_oe);
    a_r9_skip_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SKIP) |-> !so_oe);
endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;
    localparam int HALF = 8;
    localparam int WRC  = 2000;

    logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0, hold_n = 1;
    logic so, so_oe;
    int checks = 0, errors = 0;
    bit mode3 = 0, oe_any = 0, done = 0;
    logic [7:0] rb [4];

    spi_mem_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        sck = 0; si = b;
        waitc(HALF);
        r = so;
        if (so_oe) oe_any = 1;
        sck = 1;
        waitc(HALF);
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            xbit(t[i], b);
            r[i] = b;
        end
    endtask

    task automatic sel();
        sck = mode3; waitc(2); cs_n = 0; oe_any = 0;
        waitc(HALF);
    endtask

    task automatic desel();
        if (!mode3) begin sck = 0; waitc(HALF); end
        cs_n = 1;
        waitc(2 * HALF);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xbyte(op, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel(); xbyte(8'h05, d); xbyte(8'h00, s); desel();
    endtask

    task automatic read_arr(input logic [15:0] a, input int n);
        logic [7:0] d;
        sel(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
        for (int i = 0; i < n; i++) xbyte(8'h00, rb[i]);
        desel();
    endtask

    task automatic wr_arr(input logic [15:0] a, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic [7:0] d;
        sel(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
        xbyte(d0, d);
        if (n > 1) xbyte(d1, d);
        if (n > 2) xbyte(d2, d);
        desel();
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 oe low while deselected", so_oe, 0);
        rdsr(s);
        chk("R1 R11 status after reset", s, 8'h00);
        chk("R1 oe low after transfer", so_oe, 0);
    endtask

    task automatic t_opcode();
        logic [7:0] s;
        cmd1(8'h0E); rdsr(s);
        chk("R2 R3 set enable with bit3", s, 8'h02);
        cmd1(8'h0C); rdsr(s);
        chk("R2 R3 clear enable with bit3", s, 8'h00);
        sel(); begin logic [7:0] d; xbyte(8'h0D, d); xbyte(8'h00, s); end desel();
        chk("R2 status read with bit3", s, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] s;
        cmd1(8'h06);
        wr_arr(16'h03FF, 1, 8'hA5, 8'h00, 8'h00);
        rdsr(s);
        chk("R5 status during write cycle", s, 8'hFF);
        read_arr(16'h03FF, 1);
        chk("R5 read ignored while busy", oe_any, 0);
        cmd1(8'h06);
        waitc(WRC + 50);
        rdsr(s);
        chk("R5 idle, enable cleared after cycle", s, 8'h00);
        cmd1(8'h06);
        wr_arr(16'h0000, 1, 8'h3C, 8'h00, 8'h00);
        waitc(WRC + 50);
    endtask

    task automatic t_nowel();
        logic [7:0] s;
        wr_arr(16'h0000, 1, 8'h99, 8'h00, 8'h00);
        rdsr(s);
        chk("R4 no write cycle without enable", s, 8'h00);
        read_arr(16'h0000, 1);
        chk("R4 data unchanged without enable", rb[0], 8'h3C);
    endtask

    task automatic t_wrap_mask();
        read_arr(16'h03FF, 2);
        chk("R7 byte at top address", rb[0], 8'hA5);
        chk("R7 wrap to address 0", rb[1], 8'h3C);
        chk("R7 oe during read", oe_any, 1);
        read_arr(16'hFC00, 1);
        chk("R6 upper address bits ignored", rb[0], 8'h3C);
    endtask

    task automatic t_page();
        cmd1(8'h06);
        wr_arr(16'h003E, 3, 8'h11, 8'h22, 8'h33);
        waitc(WRC + 50);
        read_arr(16'h003E, 2);
        chk("R8 first page byte", rb[0], 8'h11);
        chk("R8 second page byte", rb[1], 8'h22);
        read_arr(16'h0020, 1);
        chk("R8 wrap to page start", rb[0], 8'h33);
    endtask

    task automatic t_invalid();
        logic [7:0] d, s;
        sel(); xbyte(8'h47, d); oe_any = 0; xbyte(8'hFF, d); xbyte(8'hFF, d); desel();
        chk("R9 upper nibble set floats output", oe_any, 0);
        sel(); xbyte(8'h07, d); oe_any = 0; xbyte(8'h00, d); desel();
        chk("R9 undefined code floats output", oe_any, 0);
        rdsr(s);
        chk("R9 next select works", s, 8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] d, r;
        logic b;
        sel(); xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h00, d);
        for (int i = 7; i >= 4; i--) begin xbit(1'b0, b); r[i] = b; end
        sck = 0; waitc(HALF);
        hold_n = 0; waitc(HALF);
        oe_any = 0;
        for (int k = 0; k < 3; k++) begin
            sck = 1; si = 1; waitc(HALF);
            if (so_oe) oe_any = 1;
            sck = 0; waitc(HALF);
            if (so_oe) oe_any = 1;
        end
        chk("R10 output floats while paused", oe_any, 0);
        hold_n = 1; waitc(HALF);
        for (int i = 3; i >= 0; i--) begin xbit(1'b0, b); r[i] = b; end
        desel();
        chk("R10 byte intact across pause", r, 8'h3C);
    endtask

    task automatic t_mode3();
        logic [7:0] s;
        mode3 = 1;
        read_arr(16'h03FF, 2);
        chk("R12 mode 3 top byte", rb[0], 8'hA5);
        chk("R12 mode 3 wrapped byte", rb[1], 8'h3C);
        rdsr(s);
        chk("R12 mode 3 status", s, 8'h00);
        mode3 = 0;
    endtask

    task automatic t_wrsr();
        logic [7:0] d, s;
        sel(); xbyte(8'h01, d); xbyte(8'h0C, d); desel();
        rdsr(s);
        chk("R4 status write ignored without enable", s, 8'h00);
        cmd1(8'h06);
        sel(); xbyte(8'h01, d); xbyte(8'h0C, d); desel();
        waitc(WRC + 50);
        rdsr(s);
        chk("R11 protect field stored", s, 8'h0C);
    endtask

    initial begin
        waitc(5); rst_n = 1; waitc(5);
        t_reset();
        t_opcode();
        t_busy();
        t_nowel();
        t_wrap_mask();
        t_page();
        t_invalid();
        t_hold();
        t_mode3();
        t_wrsr();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        waitc(190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule